// File: doc/BRIEF.md
# Shared-Lockout Switch Debouncer

This block cleans up a bank of mechanical switch inputs with a single blanking timer that all channels share, so no channel needs a stable-time counter of its own. Each raw input first passes through a two-stage synchronizer. The block is idle while the timer is at zero. In that state, any synchronized level that differs from the held output is copied to the output at once, and a one-cycle change pulse is raised for that bit.

The same acceptance reloads the shared timer. Until the timer runs out, every level change on every channel is ignored, so contact bounce is masked. Presses and releases are handled alike. A difference that is still present when the timer runs out is accepted on the first idle cycle, and that acceptance starts a new blanking period. The blanking length is a cycle count times an optional prescale factor, so a long real-time window needs only a short counter.

Top module: `sw_debounce_shared`

## Requirements
- R1: While rst_n is low at a clock edge, sw_clean and sw_toggle are all zero after that edge.
- R2: When the block is idle, a level change held on sw_raw from just after one rising edge appears on sw_clean after the third rising edge that follows.
- R3: On an accepting edge, every bit whose synchronized level differs from sw_clean is loaded in that same edge. sw_toggle is 1 for exactly those bits for one cycle and is zero in the next cycle.
- R4: After an accepting edge, sw_clean and sw_toggle do not change for the next LOCK_TICKS*PRESCALE edges, whatever sw_raw does.
- R5: Rising and falling switch levels are both accepted, and both start the blanking period.
- R6: A difference that remains when the blanking period ends is accepted exactly LOCK_TICKS*PRESCALE+1 edges after the previous acceptance.
- R7: Bounce bursts that settle within the blanking period produce exactly one sw_toggle pulse per channel for each real level change, and sw_clean settles to the final levels.
- R8: sw_clean changes a bit only in the cycle where sw_toggle shows a 1 on that bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sw_raw | input | NUM_SW | Asynchronous switch levels |
| sw_clean | output | NUM_SW | Debounced switch levels |
| sw_toggle | output | NUM_SW | One-cycle pulse on each bit accepted this cycle |

## Verification
The bound checker tests the following on every cycle: the reset values, that a pulse never lasts more than one cycle, that each output change is matched by a pulse on the same bit, and that no pulse arrives inside the blanking window. It tracks that window with its own gap counter. The checker does not see the raw levels, so it cannot show that ignored glitches are truly lost, or that a pending difference is picked up on the first idle cycle. The bench's reference model and its scenarios cover those cases: bounce bursts on several channels, a glitch inside the window, and a change that is held across the end of the window.

// File: rtl/dbn_pkg.sv
// Package: shared helpers for the shared-lockout debouncer.
// Assumes: widths are small positive integers.
package dbn_pkg;

    // Bits needed to hold the value n (at least one bit).
    function automatic int unsigned cnt_width(input int unsigned n);
        int unsigned w;
        w = $clog2(n + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/dbn_sync_bank.sv
// Module: dbn_sync_bank
// Brings WIDTH asynchronous levels into the clock domain through a chain of
// STAGES flops per bit. Assumes STAGES >= 2 and that the inputs are levels.
module dbn_sync_bank #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain_q;

            // Shift the raw level through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q <= '0;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], async_in[b]};
                end
            end

            assign sync_out[b] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/dbn_lockout_timer.sv
// Module: dbn_lockout_timer
// One blanking timer for all channels. A load pulse sets the count to
// LOCK_TICKS. The count then falls by one every PRESCALE cycles, and
// idle_o is high once it reaches zero. Assumes LOCK_TICKS >= 1 and
// PRESCALE >= 1. The prescaler restarts on every load, so each window
// lasts exactly LOCK_TICKS*PRESCALE cycles.
module dbn_lockout_timer
    import dbn_pkg::*;
#(
    parameter int unsigned LOCK_TICKS = 16,
    parameter int unsigned PRESCALE   = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic idle_o
);

    localparam int unsigned CW = cnt_width(LOCK_TICKS);
    localparam logic [CW-1:0] LOAD_VAL = CW'(LOCK_TICKS);

    logic [CW-1:0] count_q;
    logic          tick;

    generate
        if (PRESCALE > 1) begin : g_prescale
            localparam int unsigned PW = cnt_width(PRESCALE - 1);
            localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);
            logic [PW-1:0] pre_q;

            // Divide the clock into ticks while the window is open.
            always_ff @(posedge clk) begin
                if (!rst_n || load_i) begin
                    pre_q <= '0;
                end else if (count_q != '0) begin
                    pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
                end
            end

            assign tick = (pre_q == PRE_LAST);
        end else begin : g_direct
            assign tick = 1'b1;
        end
    endgenerate

    // Reload on acceptance, otherwise count the window down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load_i) begin
            count_q <= LOAD_VAL;
        end else if (count_q != '0 && tick) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign idle_o = (count_q == '0);

endmodule

// File: rtl/dbn_capture.sv
// Module: dbn_capture
// Holds the debounced levels. When enabled (timer idle), it takes every bit
// that differs from the synchronized input in one edge, pulses those bits for
// one cycle, and requests a timer load. Assumes sync_i is already in the
// clock domain.
module dbn_capture #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [WIDTH-1:0] sync_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] pulse_o,
    output logic             accept_o
);

    logic [WIDTH-1:0] level_q;
    logic [WIDTH-1:0] pulse_q;
    logic [WIDTH-1:0] differ;

    // Bits where the input has moved away from the held level.
    always_comb begin
        differ   = sync_i ^ level_q;
        accept_o = enable_i && (differ != '0);
    end

    // Load all differing bits at once and mark them for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            pulse_q <= '0;
        end else if (accept_o) begin
            level_q <= sync_i;
            pulse_q <= differ;
        end else begin
            pulse_q <= '0;
        end
    end

    assign level_o = level_q;
    assign pulse_o = pulse_q;

endmodule

// File: rtl/sw_debounce_shared.sv
// Module: sw_debounce_shared
// Debounces NUM_SW switch levels with one blanking timer for all of them.
// The first change is passed through at once, and later changes are ignored
// until LOCK_TICKS*PRESCALE cycles have passed. Assumes slow mechanical
// inputs and a synchronous active-low reset.
module sw_debounce_shared #(
    parameter int unsigned NUM_SW      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned LOCK_TICKS  = 16,
    parameter int unsigned PRESCALE    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SW-1:0] sw_raw,
    output logic [NUM_SW-1:0] sw_clean,
    output logic [NUM_SW-1:0] sw_toggle
);

    logic [NUM_SW-1:0] sw_sync;
    logic              timer_idle;
    logic              accept;

    dbn_sync_bank #(
        .WIDTH (NUM_SW),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(sw_raw),
        .sync_out(sw_sync)
    );

    dbn_capture #(
        .WIDTH(NUM_SW)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable_i(timer_idle),
        .sync_i  (sw_sync),
        .level_o (sw_clean),
        .pulse_o (sw_toggle),
        .accept_o(accept)
    );

    dbn_lockout_timer #(
        .LOCK_TICKS(LOCK_TICKS),
        .PRESCALE  (PRESCALE)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(accept),
        .idle_o(timer_idle)
    );

endmodule

// File: rtl/dbn_checker.sv
// Module: dbn_checker
// Port-level properties of the shared-lockout debouncer. Keeps its own gap
// counter of edges since the last pulse, so the blanking window can be
// checked without a long $past.
module dbn_checker
    import dbn_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned WIN   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] lvl,
    input logic [WIDTH-1:0] pls
);

    localparam int unsigned GW = cnt_width(WIN);
    localparam logic [GW-1:0] GAP_MAX = GW'(WIN);

    logic [WIDTH-1:0] prev_lvl;
    logic [GW-1:0]    gap_q;

    // Remember the level seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_lvl <= '0;
        else        prev_lvl <= lvl;
    end

    // Count edges since the last pulse, saturating at the window length.
    always_ff @(posedge clk) begin
        if (!rst_n)           gap_q <= GAP_MAX;
        else if (pls != '0)   gap_q <= '0;
        else if (gap_q < GAP_MAX) gap_q <= gap_q + 1'b1;
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (lvl == '0 && pls == '0));

    // R3
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pls != '0) |=> (pls == '0));

    // R8
    pulse_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((lvl ^ prev_lvl) == pls));

    // R4
    lock_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pls != '0) |-> (gap_q >= GAP_MAX));

endmodule

bind sw_debounce_shared dbn_checker #(
    .WIDTH(NUM_SW),
    .WIN  (LOCK_TICKS * PRESCALE)
) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (sw_clean),
    .pls  (sw_toggle)
);

// File: tb/sw_debounce_shared_bench.sv
// Bench: behavioural reference model compared on every clock, plus scenario
// checks for latency, grouping, blanking, pending acceptance and bounce.
module sw_debounce_shared_bench;

    localparam int N   = 8;
    localparam int L   = 16;
    localparam int P   = 1;
    localparam int WIN = L * P;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] sw_raw = '0;
    logic [N-1:0] sw_clean;
    logic [N-1:0] sw_toggle;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int pc   [N];
    int lastp[N];
    int exp_pc[N];
    logic [N-1:0] settled = '0;

    // Reference model state.
    logic [N-1:0] syncq[$];
    logic [N-1:0] m_out = '0;
    logic [N-1:0] m_pulse = '0;
    logic [N-1:0] m_s2;
    logic [N-1:0] m_diff;
    int           m_left = 0;

    sw_debounce_shared #(.NUM_SW(N), .LOCK_TICKS(L), .PRESCALE(P)) u_sw_debounce_shared (
        .clk(clk), .rst_n(rst_n), .sw_raw(sw_raw),
        .sw_clean(sw_clean), .sw_toggle(sw_toggle)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Behavioural model: two-deep delay queue, then a shared blanking count.
    always @(posedge clk) begin
        if (!rst_n) begin
            syncq = '{'0, '0};
            m_out = '0; m_pulse = '0; m_left = 0;
        end else begin
            m_s2   = syncq[0];
            m_diff = m_s2 ^ m_out;
            if (m_left == 0 && m_diff != '0) begin
                m_pulse = m_diff; m_out = m_s2; m_left = WIN;
            end else begin
                m_pulse = '0;
                if (m_left > 0) m_left--;
            end
            syncq.push_back(sw_raw);
            void'(syncq.pop_front());
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Compare with the model and log pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(sw_clean == m_out, "R2 R3 R4 model sw_clean", sw_clean, m_out);
            chk(sw_toggle == m_pulse, "R3 R5 R6 model sw_toggle", sw_toggle, m_pulse);
            for (int b = 0; b < N; b++) begin
                if (sw_toggle[b]) begin
                    pc[b]++;
                    lastp[b] = cyc;
                end
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Record which real level changes the stimulus has made.
    task automatic settle();
        for (int b = 0; b < N; b++)
            if (sw_raw[b] != settled[b]) exp_pc[b]++;
        settled = sw_raw;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int c0;
        logic [7:0] p0, p2, p7;
        for (int b = 0; b < N; b++) begin pc[b] = 0; lastp[b] = 0; exp_pc[b] = 0; end
        wait_cyc(4);
        chk(sw_clean == '0, "R1 reset sw_clean", sw_clean, 0);
        chk(sw_toggle == '0, "R1 reset sw_toggle", sw_toggle, 0);
        rst_n = 1'b1;
        wait_cyc(5);

        // R2: latency of three edges when idle.
        c0 = cyc; sw_raw[0] = 1'b1;
        wait_cyc(25); settle();
        chk(lastp[0] == c0 + 3, "R2 latency", lastp[0] - c0, 3);
        chk(sw_clean[0] == 1'b1, "R2 level", sw_clean[0], 1);

        // R3: two bits changing together share one pulse.
        sw_raw[2:1] = 2'b11;
        wait_cyc(25); settle();
        chk(pc[1] == 1 && pc[2] == 1, "R3 pulse count", pc[1] + pc[2], 2);
        chk(lastp[1] == lastp[2], "R3 same cycle", lastp[1], lastp[2]);

        // R5: a release is accepted too.
        sw_raw[0] = 1'b0;
        wait_cyc(25); settle();
        chk(sw_clean[0] == 1'b0, "R5 release level", sw_clean[0], 0);
        chk(pc[0] == 2, "R5 release pulse", pc[0], 2);

        // R4: a glitch inside the window is lost.
        sw_raw[6] = 1'b1;
        wait_cyc(5); sw_raw[5] = 1'b1;
        wait_cyc(3); sw_raw[5] = 1'b0;
        wait_cyc(30); settle();
        chk(pc[5] == 0, "R4 ignored pulse", pc[5], 0);
        chk(sw_clean[5] == 1'b0, "R4 ignored level", sw_clean[5], 0);
        chk(pc[6] == 1, "R4 trigger pulse", pc[6], 1);

        // R6: a change held through the window is taken right after it.
        sw_raw[3] = 1'b1;
        wait_cyc(5); sw_raw[4] = 1'b1;
        wait_cyc(40); settle();
        chk(lastp[4] - lastp[3] == WIN + 1, "R6 pending gap", lastp[4] - lastp[3], WIN + 1);

        // R7: bounce bursts on several channels, press then release.
        p0 = 8'b1111_0101; p2 = 8'b0000_1010; p7 = 8'b1101_0100;
        for (int i = 0; i < 8; i++) begin
            sw_raw[0] = p0[i]; sw_raw[2] = p2[i]; sw_raw[7] = p7[i];
            wait_cyc(1);
        end
        wait_cyc(40); settle();
        for (int i = 0; i < 8; i++) begin
            sw_raw[0] = ~p0[i]; sw_raw[2] = ~p2[i]; sw_raw[7] = ~p7[i];
            wait_cyc(1);
        end
        wait_cyc(40); settle();
        for (int b = 0; b < N; b++)
            chk(pc[b] == exp_pc[b], $sformatf("R7 pulses ch%0d", b), pc[b], exp_pc[b]);
        chk(sw_clean == sw_raw, "R7 settled levels", sw_clean, sw_raw);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule